// File: doc/BRIEF.md
# Fractional Clock Divider with Phase Error Output

This block divides a fast input clock by a ratio of the form N + F/D, where N is an integer of at least 2 and F/D is a proper fraction. Every output period lasts either N or N+1 input cycles. A fraction accumulator picks between the two so that, over any run of D periods, the cycle count comes out exact. The average output frequency therefore has no error at all. A 30-bit denominator gives a ratio step finer than one part per billion.

Each period ends with some timing error against an ideal waveform. The block reports this error on a fixed-point word, in units of one input period, for a downstream phase-correction stage. A new ratio is written with a single-cycle strobe. It takes effect at the start of the next output period, and the accumulator starts again from zero at that point. Several instances, each with its own ratio, can run from one shared fast clock.

Top module: `frac_clk_div`

## Requirements
- R1: Each output period lasts N or N+1 input cycles. The period length comes from the accumulator value a held at the period's start. If a+F >= D the period is N+1 cycles long and the accumulator becomes a+F-D. Otherwise the period is N cycles long and the accumulator becomes a+F.
- R2: The first D periods after a ratio takes effect add up to exactly N*D+F input cycles.
- R3: clk_o is high for the first floor(L/2) cycles of a period of length L and low for the rest. It rises on the first cycle of every period.
- R4: When clk_o rises, phase_err_o already holds floor(a*2^16/D), where a is the accumulator value just updated for the new period and D is the denominator that period uses.
- R5: A strobe on load_i with a valid ratio takes effect at the start of the next output period, and the accumulator restarts from 0 there. If several strobes come before that boundary, the last valid one wins.
- R6: A strobe with an invalid ratio is ignored: int_i < 2, den_i = 0, or num_i >= den_i.
- R7: During and after reset, clk_o is low and phase_err_o is 0. The default ratio is 2 + 0/1, so the output periods are 2 cycles long until the first load.
- R8: Denominators up to 2^30-1 are accepted and handled exactly, which gives a ratio resolution finer than 1 ppb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Strobe that requests a new ratio |
| int_i | input | 8 | Integer part N |
| num_i | input | 30 | Fraction numerator F |
| den_i | input | 30 | Fraction denominator D |
| clk_o | output | 1 | Divided clock |
| phase_err_o | output | 16 | Accumulator residue scaled to 2^-16 of an input period |

## Verification
Random ratios with small denominators cycle the accumulator through many overflows. This separates a correct N/N+1 choice and residue from an off-by-one in the comparison or the subtraction. A directed ratio of 3 + 7/10 is summed over ten periods to show that the average is exact. A denominator near 2^30 exercises the full-width residue and the long scaling divide. Invalid loads, back-to-back loads and integer parts of 2 and 3 separate deferred loading, last-writer-wins and the high-time rounding from a design that applies a ratio early or mishandles odd divisors.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int INT_W  = 8;
  localparam int FRAC_W = 30;
  localparam int CNT_W  = INT_W + 1;

  typedef struct packed {
    logic [INT_W-1:0]  n;
    logic [FRAC_W-1:0] f;
    logic [FRAC_W-1:0] d;
  } ratio_t;

  localparam ratio_t RATIO_RST = '{n: INT_W'(2), f: '0, d: FRAC_W'(1)};
endpackage

// File: rtl/fcd_cfg_hold.sv
module fcd_cfg_hold
  import fcd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  ratio_t req_i,
  input  logic   bnd_i,
  output ratio_t use_o,
  output logic   restart_o,
  output ratio_t act_o
);
  ratio_t act_q, pend_q;
  logic   pend_v_q;
  logic   load_ok;

  assign load_ok = load_i && (req_i.n >= INT_W'(2)) && (req_i.d != '0) && (req_i.f < req_i.d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= RATIO_RST;
      pend_q   <= RATIO_RST;
      pend_v_q <= 1'b0;
    end else begin
      if (load_ok) pend_q <= req_i;
      pend_v_q <= load_ok | (pend_v_q & ~bnd_i);
      if (bnd_i && pend_v_q) act_q <= pend_q;
    end
  end

  // the period that starts at a boundary takes the pending ratio if there is one
  assign use_o     = pend_v_q ? pend_q : act_q;
  assign restart_o = pend_v_q;
  assign act_o     = act_q;

  a_r5_cfg_only_at_bnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(act_q));
  a_r6_bad_load_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !load_ok) |=> $stable(pend_q));
endmodule

// File: rtl/fcd_frac_acc.sv
module fcd_frac_acc
  import fcd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bnd_i,
  input  logic              restart_i,
  input  ratio_t            use_i,
  output logic [CNT_W-1:0]  div_nxt_o,
  output logic [FRAC_W-1:0] res_nxt_o,
  output logic [FRAC_W-1:0] res_q_o
);
  logic [FRAC_W-1:0] acc_q, base;
  logic [FRAC_W:0]   sum, diff;
  logic              carry;

  assign base  = restart_i ? '0 : acc_q;
  assign sum   = {1'b0, base} + {1'b0, use_i.f};
  assign diff  = sum - {1'b0, use_i.d};
  assign carry = (sum >= {1'b0, use_i.d});

  assign res_nxt_o = carry ? diff[FRAC_W-1:0] : sum[FRAC_W-1:0];
  assign div_nxt_o = {1'b0, use_i.n} + {{INT_W{1'b0}}, carry};
  assign res_q_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (bnd_i) acc_q <= res_nxt_o;
  end

  a_r1_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(acc_q));
endmodule

// File: rtl/fcd_phase_scale.sv
module fcd_phase_scale
  import fcd_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic [FRAC_W-1:0]  rem_i,
  input  logic [FRAC_W-1:0]  den_i,
  output logic [PHASE_W-1:0] q_o
);
  // restoring divide of rem*2^PHASE_W by den, rem < den
  logic [FRAC_W:0] r [PHASE_W+1];
  assign r[0] = {1'b0, rem_i};

  for (genvar i = 0; i < PHASE_W; i++) begin : g_stage
    logic [FRAC_W:0] sh;
    logic            take;
    assign sh   = {r[i][FRAC_W-1:0], 1'b0};
    assign take = (sh >= {1'b0, den_i});
    assign r[i+1] = take ? (sh - {1'b0, den_i}) : sh;
    assign q_o[PHASE_W-1-i] = take;
  end
endmodule

// File: rtl/fcd_period_gen.sv
module fcd_period_gen
  import fcd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] div_nxt_i,
  output logic             bnd_o,
  output logic [CNT_W-1:0] div_o,
  output logic             clk_o
);
  logic [CNT_W-1:0] cnt_q, div_q, cnt_inc, half;
  logic             clk_q;

  assign bnd_o   = (cnt_q == div_q - CNT_W'(1));
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign half    = div_q >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(1);
      div_q <= CNT_W'(2);
      clk_q <= 1'b0;
    end else if (bnd_o) begin
      cnt_q <= '0;
      div_q <= div_nxt_i;
      clk_q <= 1'b1;
    end else begin
      cnt_q <= cnt_inc;
      clk_q <= (cnt_inc < half);
    end
  end

  assign div_o = div_q;
  assign clk_o = clk_q;

  a_r3_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_o |=> clk_o);
  a_r3_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < div_q);
  a_r3_low_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_o |-> !clk_o);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import fcd_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [INT_W-1:0]   int_i,
  input  logic [FRAC_W-1:0]  num_i,
  input  logic [FRAC_W-1:0]  den_i,
  output logic               clk_o,
  output logic [PHASE_W-1:0] phase_err_o
);
  ratio_t             req, use_r, act;
  logic               restart, bnd;
  logic [CNT_W-1:0]   div_nxt, div_cur;
  logic [FRAC_W-1:0]  res_nxt, res_q;
  logic [PHASE_W-1:0] phase_nxt, phase_q;

  assign req = '{n: int_i, f: num_i, d: den_i};

  fcd_cfg_hold u_cfg (
    .clk_i, .rst_ni, .load_i, .req_i(req), .bnd_i(bnd),
    .use_o(use_r), .restart_o(restart), .act_o(act)
  );

  fcd_frac_acc u_acc (
    .clk_i, .rst_ni, .bnd_i(bnd), .restart_i(restart), .use_i(use_r),
    .div_nxt_o(div_nxt), .res_nxt_o(res_nxt), .res_q_o(res_q)
  );

  fcd_phase_scale #(.PHASE_W(PHASE_W)) u_scale (
    .rem_i(res_nxt), .den_i(use_r.d), .q_o(phase_nxt)
  );

  fcd_period_gen u_per (
    .clk_i, .rst_ni, .div_nxt_i(div_nxt), .bnd_o(bnd), .div_o(div_cur), .clk_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  phase_q <= '0;
    else if (bnd) phase_q <= phase_nxt;
  end

  assign phase_err_o = phase_q;

  a_r1_div_choice: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_cur == {1'b0, act.n}) || (div_cur == {1'b0, act.n} + CNT_W'(1)));
  a_r4_res_below_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q < act.d);
  a_r4_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(phase_err_o));
endmodule

// File: tb/frac_clk_div_tb_top.sv
`timescale 1ns/1ps
module frac_clk_div_tb_top;
  localparam int P = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [7:0]  int_v = '0;
  logic [29:0] num_v = '0, den_v = '0;
  logic        clk_out;
  logic [P-1:0] phase;

  always #2.5 clk = ~clk;

  frac_clk_div #(.PHASE_W(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .int_i(int_v), .num_i(num_v),
    .den_i(den_v), .clk_o(clk_out), .phase_err_o(phase)
  );

  int checks = 0, fails = 0;
  string tag = "R7";
  longint m_n = 2, m_f = 0, m_d = 1, m_acc = 0, exp_div = 0;
  longint p_n, p_f, p_d;
  bit p_v = 0;
  int cyc = 0, hi = 0, last_len = 0;
  bit prev = 0, started = 0;
  event rise_ev;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit valid(longint n, longint f, longint d);
    return n >= 2 && n < 256 && d != 0 && f < d;
  endfunction

  function automatic longint scale(longint a, longint d);
    return (a << P) / d;
  endfunction

  // monitor and reference model
  always @(negedge clk) begin
    if (!rst_n) begin
      prev = 0; cyc = 0; hi = 0; started = 0;
    end else begin
      if (clk_out && !prev) begin
        if (started) begin
          chk(cyc == exp_div, {tag, " period length R1"}, cyc, exp_div);
          chk(hi == exp_div / 2, "R3 high time", hi, exp_div / 2);
        end
        last_len = cyc;
        if (p_v) begin
          m_n = p_n; m_f = p_f; m_d = p_d; m_acc = 0; p_v = 0;
        end
        if (m_acc + m_f >= m_d) begin
          exp_div = m_n + 1; m_acc = m_acc + m_f - m_d;
        end else begin
          exp_div = m_n; m_acc = m_acc + m_f;
        end
        chk(phase == P'(scale(m_acc, m_d)), "R4 phase error", phase, scale(m_acc, m_d));
        cyc = 1; hi = 1; started = 1;
        -> rise_ev;
      end else begin
        cyc++;
        if (clk_out) hi++;
      end
      prev = clk_out;
    end
  end

  task automatic drive(longint n, longint f, longint d);
    load = 1'b1; int_v = 8'(n); num_v = 30'(f); den_v = 30'(d);
    if (valid(n, f, d)) begin
      p_n = n; p_f = f; p_d = d; p_v = 1;
    end
  endtask

  task automatic do_load(longint n, longint f, longint d);
    @(rise_ev);
    drive(n, f, d);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_rises(int k);
    repeat (k) @(rise_ev);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    longint sum;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(clk_out == 1'b0, "R7 reset clk", clk_out, 0);
    chk(phase == '0, "R7 reset phase", phase, 0);
    rst_n = 1'b1;
    wait_rises(6);

    // R2: exact average over D periods
    tag = "R2";
    do_load(3, 7, 10);
    @(rise_ev);
    sum = 0;
    repeat (10) begin
      @(rise_ev);
      sum += last_len;
    end
    chk(sum == 37, "R2 total cycles over D periods", sum, 37);

    // R6: invalid ratios ignored
    tag = "R6";
    do_load(1, 0, 5);
    wait_rises(4);
    do_load(4, 0, 0);
    wait_rises(4);
    do_load(4, 6, 5);
    wait_rises(4);
    chk(m_n == 3 && m_d == 10, "R6 ratio kept", m_n, 3);

    // R5: two loads in one period, last one wins
    tag = "R5";
    @(rise_ev);
    drive(5, 1, 3);
    @(negedge clk);
    drive(4, 2, 7);
    @(negedge clk);
    load = 1'b0;
    wait_rises(2);
    chk(m_n == 4 && m_d == 7, "R5 last load wins", m_n, 4);
    wait_rises(8);

    // R3 odd and minimum divisors
    tag = "R3";
    do_load(2, 1, 2);
    wait_rises(8);
    do_load(7, 0, 1);
    wait_rises(4);

    // R8: full-width denominator
    tag = "R8";
    do_load(5, 999999999, 1000000007);
    wait_rises(20);
    do_load(2, 1, 1073741823);
    wait_rises(10);

    // R1: random ratios
    tag = "R1";
    for (int i = 0; i < 16; i++) begin
      longint n, d, f;
      n = 2 + ($urandom % 8);
      d = 1 + ($urandom % 1000);
      f = $urandom % d;
      do_load(n, f, d);
      wait_rises(d < 30 ? int'(d) + 3 : 30);
    end
    finish_run();
  end
endmodule